// File: doc/BRIEF.md
# Memory Operand Offset Generator

This block turns the already decoded addressing fields of a memory operand into the offset within a segment and the index of the segment register to use. It accepts the two-bit mode field, the three-bit register/memory field, the optional scale/index/base fields, a displacement already sign-extended by the decoder, a flag selecting 16-bit or 32-bit addressing and an optional segment override. It reads up to two general registers through two combinational read ports that it addresses by index. The result is registered, so each request's answer appears one clock later.

Under 16-bit addressing the offset is a sum of fixed register pairs plus the displacement, wrapped to 16 bits. Under 32-bit addressing it is a single register plus displacement, or a scaled index plus a base plus displacement, wrapped to 32 bits. Forms built on the stack or frame pointer default to the stack segment, and some encodings drop the base or the index. A mode field of 3 names a register operand and is flagged as illegal input.

Top module: `eag_top`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_illegal, out_offset and out_seg are all zero.
- R2: out_valid is high exactly in the cycle after a cycle with req_valid high; offset, segment and illegal flag of that request appear in the same cycle.
- R3: With addr32 low, the offset is the 16-bit sum of displacement and registers chosen by rm (register indices BX=3, BP=5, SI=6, DI=7): rm 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX; bits 31..16 of out_offset are zero.
- R4: With addr32 low, rm=6 and mod=0 give the displacement alone; rm 2, 3, and 6 with nonzero mod default to segment code 2 (SS); every other form defaults to code 3 (DS). Codes: ES 0, CS 1, SS 2, DS 3, FS 4, GS 5.
- R5: With addr32 high and rm not 4, the offset is register rm plus displacement modulo 2^32; rm=5 with mod=0 is displacement alone with DS; rm=5 with nonzero mod uses register 5 with SS; other rm use DS.
- R6: With addr32 high and rm=4 (scaled form), the offset is (index register shifted left by scale) plus base term plus displacement modulo 2^32, and an index value of exactly 4 contributes zero.
- R7: In the scaled form, base value 4 adds register 4 and defaults to SS; base 5 with mod=0 adds no base register and defaults to DS; base 5 with mod 1 or 2 adds register 5 and defaults to SS; any other base adds that register with DS.
- R8: When seg_ovr_valid is high, out_seg equals seg_ovr whatever the default would be.
- R9: mod=3 sets out_illegal high and out_offset to zero; otherwise out_illegal is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| field_mod | input | 2 | Mode field |
| field_rm | input | 3 | Register/memory field |
| sib_scale | input | 2 | Scale field (shift amount) |
| sib_index | input | 4 | Index register field |
| sib_base | input | 4 | Base register field |
| disp | input | 32 | Sign-extended displacement |
| seg_ovr_valid | input | 1 | Segment override present |
| seg_ovr | input | 3 | Override segment code |
| rd_base_idx | output | 4 | Register index for base read port |
| rd_base_data | input | 32 | Base read port data |
| rd_index_idx | output | 4 | Register index for index read port |
| rd_index_data | input | 32 | Index read port data |
| out_valid | output | 1 | Result valid |
| out_offset | output | 32 | Computed offset |
| out_seg | output | 3 | Selected segment code |
| out_illegal | output | 1 | Request held a register operand |

## Verification
Every result of a request (offset, segment, illegal flag and the valid pulse) is due one clock after the edge that samples the request, with the read ports answered in the same cycle as the request. The bench drives each request on a falling edge, lets the next rising edge capture it, and compares all outputs on the following falling edge, then confirms on the falling edge after that that the valid pulse has ended. Sweeps cover every mod and rm under both address sizes, every scale, index and base combination of the scaled form, several displacements including negative ones, overrides, and register values large enough that the sums wrap.

// File: rtl/eag_pkg.sv
// Package: shared types and constants of the offset generator.
// Assumes a 16-entry register file (4-bit indices) and 3-bit segment codes.
package eag_pkg;
    localparam int REG_IDX_W = 4;
    localparam int SEG_W     = 3;

    localparam logic [SEG_W-1:0] SEG_ES = 3'd0;
    localparam logic [SEG_W-1:0] SEG_CS = 3'd1;
    localparam logic [SEG_W-1:0] SEG_SS = 3'd2;
    localparam logic [SEG_W-1:0] SEG_DS = 3'd3;

    localparam logic [REG_IDX_W-1:0] IDX_BX = 4'd3;
    localparam logic [REG_IDX_W-1:0] IDX_SP = 4'd4;
    localparam logic [REG_IDX_W-1:0] IDX_BP = 4'd5;
    localparam logic [REG_IDX_W-1:0] IDX_SI = 4'd6;
    localparam logic [REG_IDX_W-1:0] IDX_DI = 4'd7;

    // Operand selection produced by either address-size decoder
    typedef struct packed {
        logic                 use_base;
        logic [REG_IDX_W-1:0] base_idx;
        logic                 use_index;
        logic [REG_IDX_W-1:0] index_idx;
        logic [1:0]           shift;
        logic                 stack_seg;
    } eag_sel_t;
endpackage

// File: rtl/eag_dec16.sv
// Module: decodes 16-bit addressing fields into an operand selection.
// Assumes mod != 3 for meaningful output; index term is never scaled.
module eag_dec16
    import eag_pkg::*;
(
    input  logic [1:0] field_mod,
    input  logic [2:0] field_rm,
    output eag_sel_t   sel
);
    // Pick the fixed register pair for each rm value
    always_comb begin
        sel = '0;
        unique case (field_rm)
            3'd0: begin sel.use_base = 1'b1; sel.base_idx = IDX_BX;
                        sel.use_index = 1'b1; sel.index_idx = IDX_SI; end
            3'd1: begin sel.use_base = 1'b1; sel.base_idx = IDX_BX;
                        sel.use_index = 1'b1; sel.index_idx = IDX_DI; end
            3'd2: begin sel.use_base = 1'b1; sel.base_idx = IDX_BP;
                        sel.use_index = 1'b1; sel.index_idx = IDX_SI;
                        sel.stack_seg = 1'b1; end
            3'd3: begin sel.use_base = 1'b1; sel.base_idx = IDX_BP;
                        sel.use_index = 1'b1; sel.index_idx = IDX_DI;
                        sel.stack_seg = 1'b1; end
            3'd4: begin sel.use_base = 1'b1; sel.base_idx = IDX_SI; end
            3'd5: begin sel.use_base = 1'b1; sel.base_idx = IDX_DI; end
            3'd6: begin
                sel.base_idx = IDX_BP;
                if (field_mod != 2'd0) begin
                    sel.use_base  = 1'b1;
                    sel.stack_seg = 1'b1;
                end
            end
            default: begin sel.use_base = 1'b1; sel.base_idx = IDX_BX; end
        endcase
    end
endmodule

// File: rtl/eag_dec32.sv
// Module: decodes 32-bit addressing fields, including the scaled form.
// Assumes mod != 3 for meaningful output; rm selects registers 0..7 only.
module eag_dec32
    import eag_pkg::*;
(
    input  logic [1:0]           field_mod,
    input  logic [2:0]           field_rm,
    input  logic [1:0]           sib_scale,
    input  logic [REG_IDX_W-1:0] sib_index,
    input  logic [REG_IDX_W-1:0] sib_base,
    output eag_sel_t             sel
);
    logic mod_zero;
    assign mod_zero = (field_mod == 2'd0);

    // Choose single-register or scaled-index form
    always_comb begin
        sel = '0;
        if (field_rm != 3'd4) begin
            sel.base_idx  = {1'b0, field_rm};
            sel.use_base  = !((field_rm == 3'd5) && mod_zero);
            sel.stack_seg = (field_rm == 3'd5) && !mod_zero;
        end else begin
            sel.index_idx = sib_index;
            sel.use_index = (sib_index != IDX_SP);
            sel.shift     = sib_scale;
            sel.base_idx  = sib_base;
            sel.use_base  = !((sib_base == IDX_BP) && mod_zero);
            sel.stack_seg = (sib_base == IDX_SP) ||
                            ((sib_base == IDX_BP) && !mod_zero);
        end
    end
endmodule

// File: rtl/eag_sum.sv
// Module: adds base, shifted index and displacement; optional 16-bit wrap.
// Assumes DATA_W >= 16; overflow is discarded silently.
module eag_sum #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic              use_base,
    input  logic [DATA_W-1:0] index_val,
    input  logic              use_index,
    input  logic [1:0]        shift,
    input  logic [DATA_W-1:0] disp,
    input  logic              narrow,
    output logic [DATA_W-1:0] offset
);
    localparam int NARROW_W = 16;

    logic [DATA_W-1:0] base_term;
    logic [DATA_W-1:0] index_term;
    logic [DATA_W-1:0] total;

    // Gate the terms, add, and optionally clip to 16 bits
    always_comb begin
        base_term  = use_base  ? base_val : '0;
        index_term = use_index ? (index_val << shift) : '0;
        total      = base_term + index_term + disp;
        offset     = narrow ? {{(DATA_W-NARROW_W){1'b0}}, total[NARROW_W-1:0]}
                            : total;
    end
endmodule

// File: rtl/eag_top.sv
// Module: memory operand offset generator, one registered stage.
// Assumes the register file answers both read ports combinationally in the
// cycle the indices are driven. Segment base and limits are handled elsewhere.
module eag_top
    import eag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 addr32,
    input  logic [1:0]           field_mod,
    input  logic [2:0]           field_rm,
    input  logic [1:0]           sib_scale,
    input  logic [REG_IDX_W-1:0] sib_index,
    input  logic [REG_IDX_W-1:0] sib_base,
    input  logic [DATA_W-1:0]    disp,
    input  logic                 seg_ovr_valid,
    input  logic [SEG_W-1:0]     seg_ovr,
    output logic [REG_IDX_W-1:0] rd_base_idx,
    input  logic [DATA_W-1:0]    rd_base_data,
    output logic [REG_IDX_W-1:0] rd_index_idx,
    input  logic [DATA_W-1:0]    rd_index_data,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_offset,
    output logic [SEG_W-1:0]     out_seg,
    output logic                 out_illegal
);
    eag_sel_t          sel16, sel32, sel;
    logic [DATA_W-1:0] sum_offset;
    logic [SEG_W-1:0]  seg_next;
    logic              illegal_next;
    logic              mode16_q;

    eag_dec16 u_dec16 (
        .field_mod (field_mod),
        .field_rm  (field_rm),
        .sel       (sel16)
    );

    eag_dec32 u_dec32 (
        .field_mod (field_mod),
        .field_rm  (field_rm),
        .sib_scale (sib_scale),
        .sib_index (sib_index),
        .sib_base  (sib_base),
        .sel       (sel32)
    );

    // Select decoder by address size and drive the read ports
    always_comb begin
        sel          = addr32 ? sel32 : sel16;
        rd_base_idx  = sel.base_idx;
        rd_index_idx = sel.index_idx;
    end

    eag_sum #(.DATA_W(DATA_W)) u_sum (
        .base_val  (rd_base_data),
        .use_base  (sel.use_base),
        .index_val (rd_index_data),
        .use_index (sel.use_index),
        .shift     (sel.shift),
        .disp      (disp),
        .narrow    (!addr32),
        .offset    (sum_offset)
    );

    // Resolve segment: override wins, else stack or data default
    always_comb begin
        illegal_next = (field_mod == 2'd3);
        if (seg_ovr_valid) seg_next = seg_ovr;
        else               seg_next = sel.stack_seg ? SEG_SS : SEG_DS;
    end

    // Register the result of each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_offset  <= '0;
            out_seg     <= '0;
            out_illegal <= 1'b0;
            mode16_q    <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_offset  <= illegal_next ? '0 : sum_offset;
                out_seg     <= seg_next;
                out_illegal <= illegal_next;
                mode16_q    <= !addr32;
            end
        end
    end

    // R2: valid follows request by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R9: illegal request reports zero offset
    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_offset == '0));
    // R3: 16-bit results never reach the upper half
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode16_q) |-> (out_offset[DATA_W-1:16] == '0));
    // R4: 16-bit displacement-only form
    a_r4_disp_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !addr32 && field_mod == 2'd0 && field_rm == 3'd6 && !seg_ovr_valid)
        |=> (out_offset[15:0] == $past(disp[15:0]) && out_seg == SEG_DS));
    // R7: scaled form with neither base nor index
    a_r7_sib_disp_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr32 && field_mod == 2'd0 && field_rm == 3'd4 &&
         sib_index == IDX_SP && sib_base == IDX_BP && !seg_ovr_valid)
        |=> (out_offset == $past(disp) && out_seg == SEG_DS));
    // R8: override replaces the default segment
    a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_ovr_valid) |=> (out_seg == $past(seg_ovr)));
endmodule

// File: tb/eag_top_tb_top.sv
`timescale 1ns/1ps
module eag_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        addr32 = 1'b0;
    logic [1:0]  field_mod = '0;
    logic [2:0]  field_rm = '0;
    logic [1:0]  sib_scale = '0;
    logic [3:0]  sib_index = '0;
    logic [3:0]  sib_base = '0;
    logic [31:0] disp = '0;
    logic        seg_ovr_valid = 1'b0;
    logic [2:0]  seg_ovr = '0;
    logic [3:0]  rd_base_idx, rd_index_idx;
    logic [31:0] rd_base_data, rd_index_data;
    logic        out_valid, out_illegal;
    logic [31:0] out_offset;
    logic [2:0]  out_seg;

    logic [31:0] regs [16];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign rd_base_data  = regs[rd_base_idx];
    assign rd_index_data = regs[rd_index_idx];

    eag_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr32(addr32),
        .field_mod(field_mod), .field_rm(field_rm), .sib_scale(sib_scale),
        .sib_index(sib_index), .sib_base(sib_base), .disp(disp),
        .seg_ovr_valid(seg_ovr_valid), .seg_ovr(seg_ovr),
        .rd_base_idx(rd_base_idx), .rd_base_data(rd_base_data),
        .rd_index_idx(rd_index_idx), .rd_index_data(rd_index_data),
        .out_valid(out_valid), .out_offset(out_offset), .out_seg(out_seg),
        .out_illegal(out_illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result for one request, from the requirements
    task automatic model(input bit a32, input int md, input int rm, input int sc,
                         input int ix, input int bs, input logic [31:0] d,
                         input bit ovv, input int ovr,
                         output logic [31:0] off, output logic [2:0] seg, output bit ill);
        bit ss = 0;
        logic [15:0] o16;
        logic [15:0] bx = regs[3][15:0], bp = regs[5][15:0];
        logic [15:0] si = regs[6][15:0], di = regs[7][15:0];
        ill = (md == 3);
        off = 0;
        if (!a32) begin
            case (rm)
                0: o16 = bx + si;
                1: o16 = bx + di;
                2: begin o16 = bp + si; ss = 1; end
                3: begin o16 = bp + di; ss = 1; end
                4: o16 = si;
                5: o16 = di;
                6: if (md == 0) o16 = 0; else begin o16 = bp; ss = 1; end
                default: o16 = bx;
            endcase
            o16 = o16 + d[15:0];
            off = {16'h0, o16};
        end else if (rm != 4) begin
            if (rm == 5 && md == 0) off = d;
            else off = regs[rm] + d;
            ss = (rm == 5 && md != 0);
        end else begin
            off = d;
            if (ix != 4) off = off + (regs[ix] << sc);
            if (bs == 4) begin off = off + regs[4]; ss = 1; end
            else if (bs == 5) begin
                if (md != 0) begin off = off + regs[5]; ss = 1; end
            end else off = off + regs[bs];
        end
        if (ill) off = 0;
        seg = ovv ? 3'(ovr) : (ss ? 3'd2 : 3'd3);
    endtask

    task automatic run(input string tag, input bit a32, input int md, input int rm,
                       input int sc, input int ix, input int bs, input logic [31:0] d,
                       input bit ovv, input int ovr);
        logic [31:0] eo; logic [2:0] es; bit ei;
        @(negedge clk);
        chk({"R2 idle ", tag}, {31'h0, out_valid}, 32'h0);
        addr32 = a32; field_mod = 2'(md); field_rm = 3'(rm); sib_scale = 2'(sc);
        sib_index = 4'(ix); sib_base = 4'(bs); disp = d;
        seg_ovr_valid = ovv; seg_ovr = 3'(ovr); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        model(a32, md, rm, sc, ix, bs, d, ovv, ovr, eo, es, ei);
        chk({"R2 valid ", tag}, {31'h0, out_valid}, 32'h1);
        chk({tag, " offset"}, out_offset, eo);
        chk({"R9 illegal ", tag}, {31'h0, out_illegal}, {31'h0, ei});
        if (!ei) chk({tag, " seg"}, {29'h0, out_seg}, {29'h0, es});
    endtask

    logic [31:0] dv [4];

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'hF000_1000 + i * 32'h0111_9F3D;
        dv[0] = 32'h0; dv[1] = 32'h7F; dv[2] = 32'hFFFF_FF80; dv[3] = 32'h1234_F678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", {31'h0, out_valid}, 32'h0);
        chk("R1 offset", out_offset, 32'h0);
        chk("R1 seg", {29'h0, out_seg}, 32'h0);
        chk("R1 illegal", {31'h0, out_illegal}, 32'h0);
        // R3/R4: 16-bit forms and segment defaults, with and without override (R8)
        for (int md = 0; md < 3; md++)
            for (int rm = 0; rm < 8; rm++)
                for (int d = 0; d < 4; d++)
                    for (int ov = 0; ov < 2; ov++)
                        run(ov ? "R8 16-bit" : "R3 R4 16-bit", 0, md, rm, 0, 0, 0,
                            dv[d], ov[0], (rm + d) % 6);
        // R5: 32-bit single-register forms, wrapping sums
        for (int md = 0; md < 3; md++)
            for (int rm = 0; rm < 8; rm++)
                for (int d = 0; d < 4; d++)
                    if (rm != 4) run("R5 32-bit", 1, md, rm, 0, 0, 0, dv[d], 0, 0);
        // R6/R7: scaled form, every scale, index and base
        for (int md = 0; md < 3; md++)
            for (int sc = 0; sc < 4; sc++)
                for (int ix = 0; ix < 16; ix++)
                    for (int bs = 0; bs < 16; bs++)
                        run("R6 R7 scaled", 1, md, 4, sc, ix, bs, dv[(ix + bs) % 4], 0, 0);
        // R8: override on scaled stack form
        for (int s = 0; s < 6; s++) run("R8 override", 1, 1, 4, 1, 2, 4, 32'h10, 1, s);
        // R9: register operand flagged
        for (int rm = 0; rm < 8; rm++) begin
            run("R9 mod3 16", 0, 3, rm, 0, 0, 0, 32'h55, 0, 0);
            run("R9 mod3 32", 1, 3, rm, 2, 1, 3, 32'h55, 0, 0);
        end
        @(negedge clk);
        chk("R2 final idle", {31'h0, out_valid}, 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule